// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block turns a 6-bit operand specifier into a resolved operand location for a 16-bit processor datapath. It owns an eight-entry, 16-bit general register file. The highest register is the program counter and the one below it is the stack pointer. The specifier's upper three bits give the addressing mode and the lower three bits name the register. The sequencer works out the effective address and issues the pointer and index-word reads that the mode needs. It applies the register side effects of the auto-increment and auto-decrement modes, and advances the program counter past any index word.

To use the block, the execution stage pulses `start_i` together with the specifier and a byte/word flag. It then waits for `done_o`. With `done_o` it receives either a register-direct indication or the final operand address. Memory reads go out over a single request/acknowledge channel, and only one read is in flight at a time. A word-sized access to an odd address is reported on `align_err_o`. When that happens the sequence is cut short and no register is changed. The register file also has a plain write port and read port, which the execution stage uses for its own results.

Top module: `opnd_addr_seq`

## Requirements
- R1: Mode 0 (specifier bits 5:3 = 0) completes with `is_reg_o`=1, `reg_sel_o` equal to bits 2:0, no memory request and no register change.
- R2: Mode 1 gives the register contents as the address. Mode 2 gives the register contents as the address and then adds the step to the register. Mode 4 subtracts the step from the register and uses the result as the address. For registers 0 to 5 the step is 1 when `byte_i`=1 and 2 when `byte_i`=0.
- R3: For register 6 (stack pointer) and register 7 (program counter), modes 2 to 5 always step by 2, even when `byte_i`=1. Mode 2 on register 7 yields the immediate word's address.
- R4: Modes 3 and 5 step the register by 2 regardless of size. Mode 3 reads a word at the old register value, and mode 5 reads it at the decremented value. The word read back is the operand address.
- R5: Modes 6 and 7 read an index word at the current PC and advance the PC by 2. Mode 6 gives register+index as the address. Mode 7 reads a word at that sum and uses it as the address. For register 7 the sum uses the advanced PC (relative addressing).
- R6: A read request is never issued to an odd address; an odd read address aborts the sequence. The sequence also aborts when `byte_i`=0 and the final operand address is odd (modes 1 to 7). An abort raises `align_err_o` with `done_o` and leaves every register unchanged.
- R7: At most one read is outstanding. `mem_req_o` and `mem_addr_o` hold steady until `mem_ack_i`, and the sequence does not advance without it.
- R8: After reset all registers read 0, and `done_o` and `mem_req_o` are low.
- R9: `done_o` is a one-cycle pulse. With a zero-wait memory, it is due 1 cycle after start for modes 0, 1, 2 and 4, 3 cycles after for modes 3, 5 and 6, and 5 cycles after for mode 7.
- R10: A write on the register port is visible on the read port in the following cycle. Register side effects land in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin resolving `spec_i` (accepted when idle) |
| spec_i | input | 6 | Mode in bits 5:3, register in bits 2:0 |
| byte_i | input | 1 | 1 = byte operand, 0 = word operand |
| done_o | output | 1 | Sequence finished (one cycle) |
| is_reg_o | output | 1 | Operand is the register itself |
| reg_sel_o | output | 3 | Register named by the specifier |
| opnd_addr_o | output | 16 | Final operand address, valid with `done_o` |
| align_err_o | output | 1 | Odd word address seen; sequence aborted |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | 16 | Read address |
| mem_ack_i | input | 1 | Read completed; `mem_rdata_i` valid |
| mem_rdata_i | input | 16 | Read data |
| rf_we_i | input | 1 | Register write enable |
| rf_widx_i | input | 3 | Register write index |
| rf_wdata_i | input | 16 | Register write data |
| rf_ridx_i | input | 3 | Register read index |
| rf_rdata_o | output | 16 | Register read data |

## Verification
The memory model answers each request one cycle after it is seen. Under that model `done_o` arrives 1, 3 or 5 cycles after the start edge, depending on how many reads the mode needs. The bench counts sampled edges from the start edge and compares the count with that figure. All outputs are sampled 1 ns after a rising edge. Register side effects commit on the edge that ends the `done_o` cycle, so register contents are read back one edge after the pulse. A separate run stretches the acknowledge latency to show that the sequence waits on it.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int DATA_W = 16;
  localparam int REG_AW = 3;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_IDX,
    ST_PTR,
    ST_FIN
  } seq_st_e;
endpackage

// File: rtl/opnd_regfile.sv
module opnd_regfile #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cm_we_i,
  input  logic [AW-1:0] cm_idx_i,
  input  logic [DW-1:0] cm_data_i,
  input  logic          ex_we_i,
  input  logic [AW-1:0] ex_idx_i,
  input  logic [DW-1:0] ex_data_i,
  input  logic [AW-1:0] ra_idx_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_data_o,
  input  logic [AW-1:0] rc_idx_i,
  output logic [DW-1:0] rc_data_o
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (cm_we_i && cm_idx_i == AW'(g)) begin
        regs_q[g] <= cm_data_i;  // sequencer side effect wins
      end else if (ex_we_i && ex_idx_i == AW'(g)) begin
        regs_q[g] <= ex_data_i;
      end
    end
  end

  assign ra_data_o = regs_q[ra_idx_i];
  assign rb_data_o = regs_q[rb_idx_i];
  assign rc_data_o = regs_q[rc_idx_i];
endmodule

// File: rtl/opnd_step.sv
module opnd_step #(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int MW = 3
) (
  input  logic [MW-1:0] mode_i,
  input  logic [AW-1:0] ridx_i,
  input  logic          byte_i,
  output logic [DW-1:0] step_o
);
  localparam int          NREG   = 1 << AW;
  localparam logic [AW-1:0] SP_IDX = AW'(NREG - 2);

  logic deferred;
  logic wide_reg;

  assign deferred = (mode_i == MW'(3)) || (mode_i == MW'(5));
  assign wide_reg = (ridx_i >= SP_IDX);
  assign step_o   = (byte_i && !deferred && !wide_reg) ? DW'(1) : DW'(2);
endmodule

// File: rtl/opnd_addr_seq.sv
module opnd_addr_seq
  import opnd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = REG_AW,
  parameter int MW = MODE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MW+AW-1:0] spec_i,
  input  logic             byte_i,
  output logic             done_o,
  output logic             is_reg_o,
  output logic [AW-1:0]    reg_sel_o,
  output logic [DW-1:0]    opnd_addr_o,
  output logic             align_err_o,
  output logic             mem_req_o,
  output logic [DW-1:0]    mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             rf_we_i,
  input  logic [AW-1:0]    rf_widx_i,
  input  logic [DW-1:0]    rf_wdata_i,
  input  logic [AW-1:0]    rf_ridx_i,
  output logic [DW-1:0]    rf_rdata_o
);
  localparam int            NREG    = 1 << AW;
  localparam logic [AW-1:0] PC_IDX  = AW'(NREG - 1);
  localparam logic [DW-1:0] PC_STEP = DW'(2);

  seq_st_e       st_q;
  logic [MW-1:0] mode_q;
  logic [AW-1:0] ridx_q;
  logic          byte_q;
  logic          err_q;
  logic [DW-1:0] addr_q;
  logic [DW-1:0] upd_q;

  logic          idle;
  logic [MW-1:0] cur_mode;
  logic [AW-1:0] cur_ridx;
  logic          cur_byte;
  logic [DW-1:0] base_rd;
  logic [DW-1:0] pc_rd;
  logic [DW-1:0] step;
  logic [DW-1:0] dec_val;
  logic [DW-1:0] pc_adv;
  logic [DW-1:0] idx_sum;
  logic          fin;
  logic          abort;
  logic          cm_we;
  logic [AW-1:0] cm_idx;

  assign idle     = (st_q == ST_IDLE);
  assign cur_mode = idle ? spec_i[MW+AW-1:AW] : mode_q;
  assign cur_ridx = idle ? spec_i[AW-1:0] : ridx_q;
  assign cur_byte = idle ? byte_i : byte_q;

  opnd_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cm_we_i   (cm_we),
    .cm_idx_i  (cm_idx),
    .cm_data_i (upd_q),
    .ex_we_i   (rf_we_i),
    .ex_idx_i  (rf_widx_i),
    .ex_data_i (rf_wdata_i),
    .ra_idx_i  (cur_ridx),
    .ra_data_o (base_rd),
    .rb_idx_i  (PC_IDX),
    .rb_data_o (pc_rd),
    .rc_idx_i  (rf_ridx_i),
    .rc_data_o (rf_rdata_o)
  );

  opnd_step #(.DW(DW), .AW(AW), .MW(MW)) u_step (
    .mode_i (cur_mode),
    .ridx_i (cur_ridx),
    .byte_i (cur_byte),
    .step_o (step)
  );

  assign dec_val = base_rd - step;
  assign pc_adv  = addr_q + PC_STEP;
  // relative addressing: PC-based index uses the advanced PC
  assign idx_sum = ((ridx_q == PC_IDX) ? pc_adv : base_rd) + mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      ridx_q <= '0;
      byte_q <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      upd_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q <= cur_mode;
            ridx_q <= cur_ridx;
            byte_q <= byte_i;
            err_q  <= 1'b0;
            addr_q <= base_rd;
            upd_q  <= base_rd;
            case (cur_mode)
              MW'(0), MW'(1): st_q <= ST_FIN;
              MW'(2): begin
                upd_q <= base_rd + step;
                st_q  <= ST_FIN;
              end
              MW'(3): begin
                upd_q <= base_rd + step;
                st_q  <= ST_PTR;
              end
              MW'(4): begin
                addr_q <= dec_val;
                upd_q  <= dec_val;
                st_q   <= ST_FIN;
              end
              MW'(5): begin
                addr_q <= dec_val;
                upd_q  <= dec_val;
                st_q   <= ST_PTR;
              end
              default: begin
                addr_q <= pc_rd;
                st_q   <= ST_IDX;
              end
            endcase
          end
        end
        ST_IDX: begin
          if (addr_q[0]) begin
            err_q <= 1'b1;
            st_q  <= ST_FIN;
          end else if (mem_ack_i) begin
            upd_q  <= pc_adv;
            addr_q <= idx_sum;
            st_q   <= (mode_q == MW'(7)) ? ST_PTR : ST_FIN;
          end
        end
        ST_PTR: begin
          if (addr_q[0]) begin
            err_q <= 1'b1;
            st_q  <= ST_FIN;
          end else if (mem_ack_i) begin
            addr_q <= mem_rdata_i;
            st_q   <= ST_FIN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign fin   = (st_q == ST_FIN);
  assign abort = err_q || (!byte_q && (mode_q != '0) && addr_q[0]);
  assign cm_we = fin && !abort && (mode_q >= MW'(2));
  assign cm_idx = (mode_q >= MW'(6)) ? PC_IDX : ridx_q;

  assign done_o      = fin;
  assign is_reg_o    = fin && (mode_q == '0);
  assign reg_sel_o   = ridx_q;
  assign opnd_addr_o = addr_q;
  assign align_err_o = fin && abort;
  assign mem_req_o   = ((st_q == ST_IDX) || (st_q == ST_PTR)) && !addr_q[0];
  assign mem_addr_o  = addr_q;
endmodule

// File: rtl/opnd_addr_seq_chk.sv
module opnd_addr_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          is_reg_o,
  input logic          align_err_o,
  input logic          mem_req_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_ack_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R7
  AST_REQ_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !mem_addr_o[0]); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_NO_REQ_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o); // R7
  AST_REG_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_reg_o |-> done_o && !align_err_o); // R1
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> done_o); // R6
endmodule

bind opnd_addr_seq opnd_addr_seq_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .is_reg_o    (is_reg_o),
  .align_err_o (align_err_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/tb_opnd_addr_seq.sv
`timescale 1ns/1ps
module tb_opnd_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  spec = '0;
  logic        byt = 1'b0;
  logic        done, is_reg, aerr, req, ack;
  logic [2:0]  rsel;
  logic [15:0] oaddr, maddr, rdata;
  logic        we = 1'b0;
  logic [2:0]  widx = '0, ridx = '0;
  logic [15:0] wdata = '0, rdat;

  int total = 0, bad = 0, hs = 0, lat = 0, cnt = 0;
  logic flip = 1'b0;
  int got_cyc; logic [15:0] got_addr; logic got_isreg, got_err;

  always #2.5 clk = ~clk;

  opnd_addr_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .spec_i(spec), .byte_i(byt),
    .done_o(done), .is_reg_o(is_reg), .reg_sel_o(rsel), .opnd_addr_o(oaddr),
    .align_err_o(aerr), .mem_req_o(req), .mem_addr_o(maddr), .mem_ack_i(ack),
    .mem_rdata_i(rdata), .rf_we_i(we), .rf_widx_i(widx), .rf_wdata_i(wdata),
    .rf_ridx_i(ridx), .rf_rdata_o(rdat)
  );

  // memory: word at address a reads as a + 0x0100 (bit 0 flipped on demand)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; cnt <= 0; rdata <= '0;
    end else if (req && !ack) begin
      if (cnt >= lat) begin
        ack <= 1'b1; rdata <= (maddr + 16'h0100) ^ {15'b0, flip}; cnt <= 0;
      end else cnt <= cnt + 1;
    end else ack <= 1'b0;
  end

  always @(posedge clk) if (req && ack) hs++;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] i, input logic [15:0] d);
    @(negedge clk); we = 1'b1; widx = i; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] i, output logic [15:0] d);
    ridx = i; #0.5; d = rdat;
  endtask

  task automatic run_op(input logic [5:0] sp, input logic by);
    @(negedge clk); spec = sp; byt = by; start = 1'b1; hs = 0;
    @(posedge clk); #1; start = 1'b0; got_cyc = 1;
    while (!done && got_cyc < 60) begin @(posedge clk); #1; got_cyc++; end
    got_addr = oaddr; got_isreg = is_reg; got_err = aerr;
    if (!done) chk("R9 timeout", 16'(got_cyc), 16'd0);
    @(posedge clk); #1;
  endtask

  typedef struct packed {
    logic [5:0]  sp; logic by; logic [15:0] base; logic [15:0] pc;
    logic [15:0] ea; logic isr; logic [15:0] ereg; logic [15:0] epc; logic [3:0] cyc;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{6'o01, 1'b0, 16'h0123, 16'h1000, 16'h0123, 1'b1, 16'h0123, 16'h1000, 4'd1}, // R1
    '{6'o12, 1'b0, 16'h0200, 16'h1000, 16'h0200, 1'b0, 16'h0200, 16'h1000, 4'd1}, // R2
    '{6'o23, 1'b1, 16'h0300, 16'h1000, 16'h0300, 1'b0, 16'h0301, 16'h1000, 4'd1}, // R2
    '{6'o23, 1'b0, 16'h0300, 16'h1000, 16'h0300, 1'b0, 16'h0302, 16'h1000, 4'd1}, // R2
    '{6'o26, 1'b1, 16'h0400, 16'h1000, 16'h0400, 1'b0, 16'h0402, 16'h1000, 4'd1}, // R3
    '{6'o44, 1'b1, 16'h0500, 16'h1000, 16'h04FF, 1'b0, 16'h04FF, 16'h1000, 4'd1}, // R2
    '{6'o46, 1'b1, 16'h0600, 16'h1000, 16'h05FE, 1'b0, 16'h05FE, 16'h1000, 4'd1}, // R3
    '{6'o35, 1'b1, 16'h0700, 16'h1000, 16'h0800, 1'b0, 16'h0702, 16'h1000, 4'd3}, // R4
    '{6'o51, 1'b1, 16'h0900, 16'h1000, 16'h09FE, 1'b0, 16'h08FE, 16'h1000, 4'd3}, // R4
    '{6'o62, 1'b0, 16'h0050, 16'h1000, 16'h1150, 1'b0, 16'h0050, 16'h1002, 4'd3}, // R5
    '{6'o72, 1'b0, 16'h0050, 16'h1000, 16'h1250, 1'b0, 16'h0050, 16'h1002, 4'd5}, // R5
    '{6'o27, 1'b1, 16'h2000, 16'h2000, 16'h2000, 1'b0, 16'h2002, 16'h2002, 4'd1}, // R3
    '{6'o37, 1'b0, 16'h2000, 16'h2000, 16'h2100, 1'b0, 16'h2002, 16'h2002, 4'd3}, // R3
    '{6'o67, 1'b0, 16'h3000, 16'h3000, 16'h6102, 1'b0, 16'h3002, 16'h3002, 4'd3}, // R5
    '{6'o77, 1'b0, 16'h3000, 16'h3000, 16'h6202, 1'b0, 16'h3002, 16'h3002, 4'd5}  // R5
  };

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired act=1 exp=0");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    #12; rst_n = 1'b1;
    @(posedge clk); #1;
    // R8 reset state
    chk("R8 done", 16'(done), 16'd0);
    chk("R8 req", 16'(req), 16'd0);
    for (int i = 0; i < 8; i++) begin rd_reg(3'(i), v); chk("R8 reg", v, 16'h0000); end

    // R10 write/read port
    wr_reg(3'd5, 16'hBEEF); rd_reg(3'd5, v); chk("R10 readback", v, 16'hBEEF);

    for (int k = 0; k < NV; k++) begin
      vec_t t = VECS[k];
      wr_reg(t.sp[2:0], t.base);
      wr_reg(3'd7, t.pc);
      run_op(t.sp, t.by);
      chk("R1 is_reg", 16'(got_isreg), 16'(t.isr));
      chk("R6 no err", 16'(got_err), 16'd0);
      if (!t.isr) chk("R2-addr", got_addr, t.ea);
      else chk("R1 no mem", 16'(hs), 16'd0);
      chk("R9 latency", 16'(got_cyc), 16'(t.cyc));
      rd_reg(t.sp[2:0], v); chk("R10 reg side effect", v, t.ereg);
      rd_reg(3'd7, v); chk("R5 pc", v, t.epc);
    end

    // R6 odd final word address aborts, register untouched
    wr_reg(3'd3, 16'h0301); run_op(6'o23, 1'b0);
    chk("R6 err word", 16'(got_err), 16'd1);
    rd_reg(3'd3, v); chk("R6 reg kept", v, 16'h0301);
    run_op(6'o23, 1'b1);
    chk("R6 byte ok", 16'(got_err), 16'd0);
    rd_reg(3'd3, v); chk("R2 byte step", v, 16'h0302);

    // R6 odd pointer address: no request
    wr_reg(3'd1, 16'h0401); run_op(6'o31, 1'b1);
    chk("R6 ptr err", 16'(got_err), 16'd1);
    chk("R6 no req", 16'(hs), 16'd0);
    rd_reg(3'd1, v); chk("R6 ptr reg kept", v, 16'h0401);

    // R6 odd fetched pointer: error only for word size
    flip = 1'b1;
    wr_reg(3'd1, 16'h0400); run_op(6'o31, 1'b0);
    chk("R6 odd ptr word", 16'(got_err), 16'd1);
    rd_reg(3'd1, v); chk("R6 odd ptr reg kept", v, 16'h0400);
    run_op(6'o31, 1'b1);
    chk("R4 odd ptr byte err", 16'(got_err), 16'd0);
    chk("R4 odd ptr byte addr", got_addr, 16'h0501);
    rd_reg(3'd1, v); chk("R4 deferred step", v, 16'h0402);
    flip = 1'b0;

    // R6 odd PC on index fetch
    wr_reg(3'd7, 16'h1001); run_op(6'o62, 1'b0);
    chk("R6 pc err", 16'(got_err), 16'd1);
    chk("R6 pc no req", 16'(hs), 16'd0);
    rd_reg(3'd7, v); chk("R6 pc kept", v, 16'h1001);

    // R7 slow memory: sequence waits for each acknowledge
    lat = 3;
    wr_reg(3'd7, 16'h3000); run_op(6'o77, 1'b0);
    chk("R7 slow addr", got_addr, 16'h6202);
    chk("R7 two reads", 16'(hs), 16'd2);
    chk("R7 waited", 16'(got_cyc > 5), 16'd1);
    lat = 0;

    finish_run();
  end
endmodule